// File: doc/BRIEF.md
# AC97 Codec Register Access Controller

This block carries codec register reads and writes across an AC97 link at the level of frame slots. A host presents a register index and, for writes, a 16-bit value, then pulses a read or a write request. On the next outgoing frame boundary the block fills the tag slot, the command-address slot and the command-data slot, with each field at its fixed bit position. A read then waits for the codec's status-address slot to echo the requested index, and captures the value carried in the status-data slot.

A separate frame serializer shifts the slots onto the link. It pulses `frame_strobe` once per outgoing frame, and on that edge the block loads the three command slots for that frame. The deserializer pulses `rx_strobe` once per received frame and presents the incoming tag, status-address and status-data slots. Completion of a read is taken from the index echo itself, not from a change in the returned value, so reading the same unchanged register twice still completes. After reset, and again after each link restart, the block first issues one throw-away read of register 0, because the first read after a codec reset is unreliable. Host requests are accepted only after that read has finished.

Top module: `ac97_reg_ctrl`

## Requirements
- R1: After reset the block shows busy=1 and ready=0. The first frame carries a read of index 0 (tx_tag=0xC000, tx_cmd_addr=0x80000). When that read is answered or times out, ready goes to 1 without a done pulse and rdata is left unchanged (0 after reset).
- R2: A write frame carries tx_tag=0xE000 (bit 15 frame valid, bit 14 command-address valid, bit 13 command-data valid). tx_cmd_addr holds bit 19=0 and the index in bits 18:12, with bits 11:0 zero. tx_cmd_data holds the value in bits 19:4, with bits 3:0 zero. done pulses for one cycle in the cycle after the issuing frame_strobe edge, and busy is then 0.
- R3: A read frame carries tx_tag=0xC000, tx_cmd_addr with bit 19=1 and the index in bits 18:12, and tx_cmd_data=0.
- R4: A write request whose host_idx is above 0x7F is dropped: busy stays 0, no later frame carries a command, and no done pulse occurs. A read request uses only host_idx[6:0].
- R5: While a read waits, an rx_strobe with rx_tag bit 14 set and rx_stat_addr[18:12] equal to the index completes it. rdata becomes rx_stat_data[19:4], done pulses for one cycle, and busy falls. rdata changes at no other time.
- R6: Reading the same register twice, with the same value returned, completes both times.
- R7: A status frame whose echoed index differs from the one requested is ignored: no done pulse, and busy stays 1.
- R8: When timeout_frames frame_strobe pulses have passed after the issuing frame without a match, err pulses for one cycle, busy falls, and rdata is unchanged. done and err are never high together.
- R9: A frame_strobe that carries no command loads tx_tag=0, tx_cmd_addr=0 and tx_cmd_data=0. Between frame_strobe pulses the slot outputs hold their values.
- R10: Requests that arrive while busy is 1 are ignored. If a read and a write are requested in the same cycle, the read is taken.
- R11: A relink pulse starts the index-0 throw-away read again: in the next cycle ready=0 and busy=1, and ready returns as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| relink | input | 1 | Pulse after a codec cold or warm reset; restarts the throw-away read |
| host_idx | input | 8 | Register index; bit 7 marks an out-of-range write |
| host_wdata | input | 16 | Write value |
| host_rd_req | input | 1 | Read request pulse |
| host_wr_req | input | 1 | Write request pulse |
| timeout_frames | input | TMO_W | Frames to wait for a read echo |
| busy | output | 1 | A request or the throw-away read is in progress |
| ready | output | 1 | The throw-away read has finished |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle read timeout pulse |
| rdata | output | 16 | Last value read |
| frame_strobe | input | 1 | Outgoing frame boundary |
| tx_tag | output | 16 | Outgoing tag slot |
| tx_cmd_addr | output | 20 | Outgoing command-address slot |
| tx_cmd_data | output | 20 | Outgoing command-data slot |
| rx_strobe | input | 1 | Incoming frame received |
| rx_tag | input | 16 | Incoming tag slot |
| rx_stat_addr | input | 20 | Incoming status-address slot |
| rx_stat_data | input | 20 | Incoming status-data slot |

## Verification
The hardest case to reach is a read that waits while frames go by carrying unrelated status. The bench holds a read open, feeds it a status frame that echoes a neighbouring index, and then steps frame strobes one at a time. This shows that the mismatch is ignored and that the error pulse arrives on exactly the configured frame. The repeated read of an unchanged value is placed directly in the vector table as two identical entries, and the link restart is driven in the middle of the run to bring the throw-away read back.

// File: rtl/ac97_rac_pkg.sv
package ac97_rac_pkg;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;
  localparam int IDX_W  = 7;
  localparam int VAL_W  = 16;
  localparam int VAL_LO = SLOT_W - VAL_W;
  localparam int IDX_LO = 12;
  // tag slot bit positions
  localparam int TAG_FRM  = 15;
  localparam int TAG_CMDA = 14;
  localparam int TAG_CMDD = 13;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } rac_state_e;
endpackage

// File: rtl/ac97_rst_sync.sv
module ac97_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic s0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      s0_q  <= 1'b1;
      rst_q <= s0_q;
    end
  end
endmodule

// File: rtl/ac97_slot_pack.sv
module ac97_slot_pack
  import ac97_rac_pkg::*;
(
  input  logic                is_read,
  input  logic [IDX_W-1:0]    idx,
  input  logic [VAL_W-1:0]    wval,
  output logic [TAG_W-1:0]    tag,
  output logic [SLOT_W-1:0]   addr_slot,
  output logic [SLOT_W-1:0]   data_slot
);
  always_comb begin
    tag                = '0;
    tag[TAG_FRM]       = 1'b1;
    tag[TAG_CMDA]      = 1'b1;
    tag[TAG_CMDD]      = ~is_read;
    addr_slot          = '0;
    addr_slot[SLOT_W-1] = is_read;
    addr_slot[IDX_LO +: IDX_W] = idx;
    data_slot          = '0;
    if (!is_read) data_slot[VAL_LO +: VAL_W] = wval;
  end
endmodule

// File: rtl/ac97_stat_match.sv
module ac97_stat_match
  import ac97_rac_pkg::*;
(
  input  logic              rx_strobe,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_stat_addr,
  input  logic [SLOT_W-1:0] rx_stat_data,
  input  logic [IDX_W-1:0]  want_idx,
  output logic              hit,
  output logic [VAL_W-1:0]  value
);
  logic unused_bits;

  assign hit   = rx_strobe && rx_tag[TAG_CMDA] &&
                 (rx_stat_addr[IDX_LO +: IDX_W] == want_idx);
  assign value = rx_stat_data[VAL_LO +: VAL_W];
  assign unused_bits = ^{rx_tag[TAG_W-1:TAG_CMDA+1], rx_tag[TAG_CMDA-1:0],
                         rx_stat_addr[SLOT_W-1], rx_stat_addr[IDX_LO-1:0],
                         rx_stat_data[VAL_LO-1:0]};
endmodule

// File: rtl/ac97_frame_timer.sv
module ac97_frame_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_n;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign last    = cnt_inc >= {1'b0, limit};

  always_comb begin
    cnt_n = cnt_q;
    if (clr)       cnt_n = '0;
    else if (tick) cnt_n = cnt_inc[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cnt_q <= '0;
    else if (clr || tick) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ac97_reg_ctrl.sv
module ac97_reg_ctrl
  import ac97_rac_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              relink,
  input  logic [7:0]        host_idx,
  input  logic [15:0]       host_wdata,
  input  logic              host_rd_req,
  input  logic              host_wr_req,
  input  logic [TMO_W-1:0]  timeout_frames,
  output logic              busy,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [15:0]       rdata,
  input  logic              frame_strobe,
  output logic [15:0]       tx_tag,
  output logic [19:0]       tx_cmd_addr,
  output logic [19:0]       tx_cmd_data,
  input  logic              rx_strobe,
  input  logic [15:0]       rx_tag,
  input  logic [19:0]       rx_stat_addr,
  input  logic [19:0]       rx_stat_data
);
  logic rst_q;

  rac_state_e         st_q, st_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [VAL_W-1:0]   wval_q, wval_n;
  logic               rd_q, rd_n;
  logic               init_q, init_n;
  logic               done_q, done_n, err_q, err_n;
  logic [VAL_W-1:0]   rdata_q, rdata_n;
  logic [TAG_W-1:0]   tag_q, tag_n, pk_tag;
  logic [SLOT_W-1:0]  ca_q, ca_n, cd_q, cd_n, pk_ca, pk_cd;
  logic               hit, tmr_clr, tmr_tick, tmr_last;
  logic [VAL_W-1:0]   hit_val;

  ac97_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  ac97_slot_pack u_pack (
    .is_read(rd_q), .idx(idx_q), .wval(wval_q),
    .tag(pk_tag), .addr_slot(pk_ca), .data_slot(pk_cd)
  );

  ac97_stat_match u_match (
    .rx_strobe(rx_strobe), .rx_tag(rx_tag), .rx_stat_addr(rx_stat_addr),
    .rx_stat_data(rx_stat_data), .want_idx(idx_q),
    .hit(hit), .value(hit_val)
  );

  assign tmr_clr  = (st_q == ST_SEND) && frame_strobe;
  assign tmr_tick = (st_q == ST_WAIT) && frame_strobe;

  ac97_frame_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_q(rst_q), .clr(tmr_clr), .tick(tmr_tick),
    .limit(timeout_frames), .last(tmr_last)
  );

  // next-state logic
  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    wval_n  = wval_q;
    rd_n    = rd_q;
    init_n  = init_q;
    done_n  = 1'b0;
    err_n   = 1'b0;
    rdata_n = rdata_q;
    tag_n   = tag_q;
    ca_n    = ca_q;
    cd_n    = cd_q;

    if (frame_strobe) begin
      tag_n = '0;
      ca_n  = '0;
      cd_n  = '0;
    end

    unique case (st_q)
      ST_IDLE: begin
        if (host_rd_req) begin
          idx_n = host_idx[IDX_W-1:0];
          rd_n  = 1'b1;
          st_n  = ST_SEND;
        end else if (host_wr_req && !host_idx[IDX_W]) begin
          idx_n  = host_idx[IDX_W-1:0];
          wval_n = host_wdata;
          rd_n   = 1'b0;
          st_n   = ST_SEND;
        end
      end
      ST_SEND: begin
        if (frame_strobe) begin
          tag_n = pk_tag;
          ca_n  = pk_ca;
          cd_n  = pk_cd;
          if (rd_q) begin
            st_n = ST_WAIT;
          end else begin
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end
        end
      end
      ST_WAIT: begin
        if (hit) begin
          if (!init_q) begin
            rdata_n = hit_val;
            done_n  = 1'b1;
          end
          init_n = 1'b0;
          st_n   = ST_IDLE;
        end else if (tmr_tick && tmr_last) begin
          err_n  = !init_q;
          init_n = 1'b0;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (relink) begin
      st_n    = ST_SEND;
      idx_n   = '0;
      rd_n    = 1'b1;
      init_n  = 1'b1;
      done_n  = 1'b0;
      err_n   = 1'b0;
      rdata_n = rdata_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q    <= ST_SEND;
      idx_q   <= '0;
      wval_q  <= '0;
      rd_q    <= 1'b1;
      init_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      tag_q   <= '0;
      ca_q    <= '0;
      cd_q    <= '0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      wval_q  <= wval_n;
      rd_q    <= rd_n;
      init_q  <= init_n;
      done_q  <= done_n;
      err_q   <= err_n;
      rdata_q <= rdata_n;
      tag_q   <= tag_n;
      ca_q    <= ca_n;
      cd_q    <= cd_n;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign ready       = ~init_q;
  assign done        = done_q;
  assign err         = err_q;
  assign rdata       = rdata_q;
  assign tx_tag      = tag_q;
  assign tx_cmd_addr = ca_q;
  assign tx_cmd_data = cd_q;
endmodule

// File: rtl/ac97_reg_ctrl_chk.sv
module ac97_reg_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        relink,
  input logic [7:0]  host_idx,
  input logic        host_rd_req,
  input logic        host_wr_req,
  input logic        busy,
  input logic        ready,
  input logic        done,
  input logic        err,
  input logic [15:0] rdata,
  input logic        frame_strobe,
  input logic [15:0] tx_tag,
  input logic [19:0] tx_cmd_addr,
  input logic [19:0] tx_cmd_data
);
  // R2
  cmd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cmd_addr[11:0] == 12'h0) && (tx_cmd_data[3:0] == 4'h0));

  // R4
  drop_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_req && !host_rd_req && host_idx[7] && !busy && !relink) |=> !busy);

  // R5
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != $past(rdata)) |-> done);

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9
  tag_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag != $past(tx_tag)) |-> $past(frame_strobe));

  // R11
  relink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relink |=> (!ready && busy));
endmodule

bind ac97_reg_ctrl ac97_reg_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_q), .relink(relink), .host_idx(host_idx),
  .host_rd_req(host_rd_req), .host_wr_req(host_wr_req), .busy(busy),
  .ready(ready), .done(done), .err(err), .rdata(rdata),
  .frame_strobe(frame_strobe), .tx_tag(tx_tag), .tx_cmd_addr(tx_cmd_addr),
  .tx_cmd_data(tx_cmd_data)
);

// File: tb/ac97_reg_ctrl_tb.sv
module ac97_reg_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_W = 8;
  localparam int NVEC = 6;
  // {is_read, idx[7:0], wdata[15:0], reply[15:0]}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 8'h02, 16'h8080, 16'h0000},
    {1'b1, 8'h02, 16'h0000, 16'h8080},
    {1'b0, 8'h7F, 16'hFFFF, 16'h0000},
    {1'b1, 8'h26, 16'h0000, 16'h000F},
    {1'b1, 8'h26, 16'h0000, 16'h000F},
    {1'b1, 8'h9A, 16'h0000, 16'h5A5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic relink = 1'b0;
  logic [7:0] host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic host_rd_req = 1'b0, host_wr_req = 1'b0;
  logic [TMO_W-1:0] timeout_frames = 8'd3;
  logic busy, ready, done, err;
  logic [15:0] rdata, tx_tag;
  logic [19:0] tx_cmd_addr, tx_cmd_data;
  logic frame_strobe = 1'b0, rx_strobe = 1'b0;
  logic [15:0] rx_tag = '0;
  logic [19:0] rx_stat_addr = '0, rx_stat_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ac97_reg_ctrl #(.TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .relink(relink), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rd_req(host_rd_req),
    .host_wr_req(host_wr_req), .timeout_frames(timeout_frames),
    .busy(busy), .ready(ready), .done(done), .err(err), .rdata(rdata),
    .frame_strobe(frame_strobe), .tx_tag(tx_tag), .tx_cmd_addr(tx_cmd_addr),
    .tx_cmd_data(tx_cmd_data), .rx_strobe(rx_strobe), .rx_tag(rx_tag),
    .rx_stat_addr(rx_stat_addr), .rx_stat_data(rx_stat_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_req(input bit rd, input logic [7:0] idx, input logic [15:0] wd);
    host_idx = idx; host_wdata = wd;
    host_rd_req = rd; host_wr_req = !rd;
    @(negedge clk);
    host_rd_req = 1'b0; host_wr_req = 1'b0;
  endtask

  task automatic frame();
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  task automatic reply(input logic [6:0] idx, input logic [15:0] val);
    rx_strobe = 1'b1; rx_tag = 16'h6000;
    rx_stat_addr = {1'b0, idx, 12'h000};
    rx_stat_data = {val, 4'hA};
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [15:0] last_rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1);
    chk("R1 ready", ready, 0);
    chk("R1 tag idle", tx_tag, 0);
    frame();
    chk("R1 dummy tag", tx_tag, 32'hC000);
    chk("R1 dummy addr", tx_cmd_addr, 32'h80000);
    reply(7'h00, 16'hBEEF);
    chk("R1 ready after", ready, 1);
    chk("R1 no done", done, 0);
    chk("R1 rdata kept", rdata, 0);
    chk("R1 idle", busy, 0);

    // vector table: R2 R3 R5 R6, R4 index masking on reads
    for (int i = 0; i < NVEC; i++) begin
      logic rd;
      logic [7:0] ix;
      logic [15:0] wd, rv;
      {rd, ix, wd, rv} = VEC[i];
      host_req(rd, ix, wd);
      chk("R2 busy after request", busy, 1);
      frame();
      if (!rd) begin
        chk("R2 tag", tx_tag, 32'hE000);
        chk("R2 addr", tx_cmd_addr, {12'h0, 1'b0, ix[6:0], 12'h000});
        chk("R2 data", tx_cmd_data, {12'h0, wd, 4'h0});
        chk("R2 done", done, 1);
        chk("R2 busy", busy, 0);
        @(negedge clk);
        chk("R2 done single", done, 0);
      end else begin
        chk("R3 tag", tx_tag, 32'hC000);
        chk("R3 R4 addr", tx_cmd_addr, {12'h0, 1'b1, ix[6:0], 12'h000});
        chk("R3 data", tx_cmd_data, 0);
        chk("R3 no done yet", done, 0);
        reply(ix[6:0], rv);
        chk("R5 R6 done", done, 1);
        chk("R5 R6 rdata", rdata, rv);
        chk("R5 busy", busy, 0);
      end
    end
    last_rd = 16'h5A5A;

    // R9 empty frame
    frame();
    chk("R9 tag", tx_tag, 0);
    chk("R9 addr", tx_cmd_addr, 0);
    chk("R9 data", tx_cmd_data, 0);

    // R4 out-of-range write dropped
    host_req(1'b0, 8'h80, 16'h1234);
    chk("R4 busy", busy, 0);
    frame();
    chk("R4 tag", tx_tag, 0);
    chk("R4 done", done, 0);

    // R7 mismatch, R8 timeout
    host_req(1'b1, 8'h10, 16'h0);
    frame();
    reply(7'h11, 16'hAAAA);
    chk("R7 no done", done, 0);
    chk("R7 busy", busy, 1);
    frame();
    chk("R8 err early 1", err, 0);
    frame();
    chk("R8 err early 2", err, 0);
    frame();
    chk("R8 err", err, 1);
    chk("R8 no done", done, 0);
    chk("R8 rdata kept", rdata, last_rd);
    chk("R8 busy", busy, 0);
    @(negedge clk);
    chk("R8 err single", err, 0);

    // R10 request while busy, read wins over write
    host_idx = 8'h05; host_wdata = 16'h7777;
    host_rd_req = 1'b1; host_wr_req = 1'b1;
    @(negedge clk);
    host_rd_req = 1'b0; host_wr_req = 1'b0;
    host_req(1'b0, 8'h06, 16'h1111);
    frame();
    chk("R10 read wins", tx_cmd_addr, 32'h85000);
    chk("R10 tag", tx_tag, 32'hC000);
    reply(7'h05, 16'h0C0C);
    chk("R10 done", done, 1);
    chk("R10 rdata", rdata, 32'h0C0C);
    frame();
    chk("R10 no later write", tx_tag, 0);

    // R11 relink
    relink = 1'b1;
    @(negedge clk);
    relink = 1'b0;
    chk("R11 ready low", ready, 0);
    chk("R11 busy", busy, 1);
    frame();
    chk("R11 dummy addr", tx_cmd_addr, 32'h80000);
    reply(7'h00, 16'h9999);
    chk("R11 ready", ready, 1);
    chk("R11 no done", done, 0);
    chk("R11 rdata kept", rdata, 32'h0C0C);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule